// File: doc/BRIEF.md
# Dual-Rail Serial Adder-Subtractor

This block adds or subtracts two operands one bit per step, least significant bit first. Each logical bit arrives as a pair of rails: the upper wire carries a token for a one and the lower wire carries a token for a zero. The result leaves on a pair with the same encoding. Inside, the arithmetic is built from synchronous threshold elements. A high-pass element fires when two or more of its inputs carry a token. A low-pass element fires when exactly one input carries a token. Two-input low-pass elements form the parity of the sum, and a three-input high-pass element forms the majority that becomes the next carry.

The carry has no load port. It can only be initialised through the data stream. A preamble step with both operands at zero clears it. A preamble step with both operands at one sets it. To subtract, the block swaps the two rails of the second operand, which inverts it. The caller then sends a preamble step that sets the carry, so A + ~B + 1 gives A − B. A pair with no token, or with a token on both rails, is the sign of a lost or corrupted token. Such a pair sets a sticky error flag, and the step it belongs to is skipped.

Top module: `dr_serial_addsub`

## Requirements
- R1: Every pair is encoded as bit 1 = true rail and bit 0 = complement rail. 2'b10 means logic one and 2'b01 means logic zero. `sumOut` uses the same encoding.
- R2: A step has `bitStep` high and valid pairs on both operands. After such a step, `sumOut` shows the effective A xor B xor carry on the clock edge that samples the step.
- R3: On a valid step the carry becomes the majority of A, effective B and the old carry. A step with both effective bits at 0 clears it, and a step with both at 1 sets it.
- R4: With `subMode` high, the rails of `pairB` are swapped before use. A set-carry preamble followed by N payload steps therefore yields (A − B) mod 2^N.
- R5: During a step, a pair of 2'b00 or 2'b11 on either operand sets `errFlag`. The flag then stays high until reset.
- R6: A step with an invalid pair leaves the carry unchanged and drives 2'b00 on `sumOut` for that step.
- R7: When `bitStep` is low, `sumOut` is 2'b00, the carry holds, and the operand pairs are ignored, even invalid ones.
- R8: Synchronous reset clears the carry and `errFlag`, and drives 2'b00 on `sumOut`.
- R9: `sumOut` never carries a token on both rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitStep | input | 1 | A bit step is presented on the operand pairs |
| subMode | input | 1 | Swap the rails of operand B (subtract) |
| pairA | input | 2 | Operand A rails {true, complement} |
| pairB | input | 2 | Operand B rails {true, complement} |
| sumOut | output | 2 | Result rails {true, complement}, registered |
| errFlag | output | 1 | Sticky lost-or-corrupted token flag |

## Verification
The assertions assume that reset is applied from time zero. They also assume that `bitStep`, `subMode` and both pairs are stable around the rising edge. They do not assume that the pairs are valid: invalid pairs are part of the checked behaviour. The stimulus changes every input only on the falling edge. It keeps the correct preamble in front of each operation, so that every compared result starts from a known carry. Rail drops and double tokens are injected on purpose, both inside steps and outside them.

// File: rtl/dr_serial_pkg.sv
package dr_serial_pkg;
  localparam int RAIL_W = 2;

  typedef enum logic {GATE_HIGH, GATE_LOW} gateKind_e;

  typedef struct packed {
    logic load;   // valid step: update carry, emit sum
    logic fault;  // step with a broken pair
  } strobe_t;
endpackage

// File: rtl/dr_thresh_gate.sv
module dr_thresh_gate
  import dr_serial_pkg::*;
#(
  parameter int        NUM_IN = 2,
  parameter int        THRESH = 2,
  parameter gateKind_e KIND   = GATE_HIGH
) (
  input  logic [NUM_IN-1:0] ins,
  output logic              fire
);
  localparam int CW = $clog2(NUM_IN + 1);
  logic [CW-1:0] tokenCnt;

  assign tokenCnt = CW'($countones(ins));

  generate
    if (KIND == GATE_HIGH) begin : g_high
      assign fire = (tokenCnt >= CW'(THRESH));
    end else begin : g_low
      assign fire = (tokenCnt == CW'(1));
    end
  endgenerate
endmodule

// File: rtl/dr_serial_ctrl.sv
module dr_serial_ctrl
  import dr_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bitStep,
  input  logic              subMode,
  input  logic [RAIL_W-1:0] pairA,
  input  logic [RAIL_W-1:0] pairB,
  output strobe_t           strb,
  output logic              aBit,
  output logic              bBit,
  output logic              errFlag
);
  logic aValid, bValid;

  assign aValid = pairA[1] ^ pairA[0];
  assign bValid = pairB[1] ^ pairB[0];

  assign strb.load  = bitStep & aValid & bValid;
  assign strb.fault = bitStep & ~(aValid & bValid);

  assign aBit = pairA[1];
  assign bBit = subMode ? pairB[0] : pairB[1];

  always_ff @(posedge clk) begin
    if (rst) errFlag <= 1'b0;
    else if (strb.fault) errFlag <= 1'b1;
  end
endmodule

// File: rtl/dr_serial_dp.sv
module dr_serial_dp
  import dr_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              aBit,
  input  logic              bBit,
  output logic [RAIL_W-1:0] sumPair,
  output logic              carryQ
);
  logic halfSum, sumBit, carryNext;

  dr_thresh_gate #(.NUM_IN(2), .THRESH(2), .KIND(GATE_LOW)) u_lpAB (
    .ins({aBit, bBit}), .fire(halfSum));

  dr_thresh_gate #(.NUM_IN(2), .THRESH(2), .KIND(GATE_LOW)) u_lpSum (
    .ins({halfSum, carryQ}), .fire(sumBit));

  dr_thresh_gate #(.NUM_IN(3), .THRESH(2), .KIND(GATE_HIGH)) u_hpCarry (
    .ins({aBit, bBit, carryQ}), .fire(carryNext));

  always_ff @(posedge clk) begin
    if (rst) begin
      carryQ  <= 1'b0;
      sumPair <= '0;
    end else if (strb.load) begin
      carryQ  <= carryNext;
      sumPair <= {sumBit, ~sumBit};
    end else begin
      sumPair <= '0;
    end
  end
endmodule

// File: rtl/dr_serial_addsub.sv
module dr_serial_addsub
  import dr_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bitStep,
  input  logic       subMode,
  input  logic [1:0] pairA,
  input  logic [1:0] pairB,
  output logic [1:0] sumOut,
  output logic       errFlag
);
  strobe_t strb;
  logic    aBit, bBit, carryQ;

  dr_serial_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bitStep(bitStep), .subMode(subMode),
    .pairA(pairA), .pairB(pairB), .strb(strb),
    .aBit(aBit), .bBit(bBit), .errFlag(errFlag));

  dr_serial_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .aBit(aBit), .bBit(bBit),
    .sumPair(sumOut), .carryQ(carryQ));
endmodule

// File: rtl/dr_serial_addsub_chk.sv
module dr_serial_addsub_chk (
  input logic       clk,
  input logic       rst,
  input logic       bitStep,
  input logic [1:0] pairA,
  input logic [1:0] pairB,
  input logic [1:0] sumOut,
  input logic       errFlag,
  input logic       carryQ
);
  logic brokenPair;
  assign brokenPair = (pairA == 2'b00) || (pairA == 2'b11) ||
                      (pairB == 2'b00) || (pairB == 2'b11);

  assert_rails_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    sumOut != 2'b11);

  assert_sum_token_R2: assert property (@(posedge clk) disable iff (rst)
    (bitStep && !brokenPair) |=> (sumOut[1] != sumOut[0]));

  assert_err_raise_R5: assert property (@(posedge clk) disable iff (rst)
    (bitStep && brokenPair) |=> errFlag);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bitStep && brokenPair) |=> ($stable(carryQ) && sumOut == 2'b00));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bitStep |=> ($stable(carryQ) && sumOut == 2'b00));

  assert_idle_noflag_R7: assert property (@(posedge clk) disable iff (rst)
    (!bitStep && !errFlag) |=> !errFlag);
endmodule

bind dr_serial_addsub dr_serial_addsub_chk u_chk (
  .clk(clk), .rst(rst), .bitStep(bitStep), .pairA(pairA), .pairB(pairB),
  .sumOut(sumOut), .errFlag(errFlag), .carryQ(carryQ));

// File: tb/tb_dr_serial_addsub.sv
module tb_dr_serial_addsub;
  localparam int NB = 8;
  localparam int NVEC = 8;
  // {isSub, a, b}
  localparam logic [2*NB:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'h00}, {1'b0, 8'h01, 8'h01}, {1'b0, 8'hFF, 8'h01},
    {1'b0, 8'hA5, 8'h5A}, {1'b1, 8'h10, 8'h01}, {1'b1, 8'h00, 8'h01},
    {1'b1, 8'h7F, 8'h7F}, {1'b1, 8'h3C, 8'hC3}};

  logic clk = 1'b0, rst = 1'b1, bitStep = 1'b0, subMode = 1'b0;
  logic [1:0] pairA = 2'b00, pairB = 2'b00;
  logic [1:0] sumOut;
  logic errFlag;
  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  dr_serial_addsub dut (
    .clk(clk), .rst(rst), .bitStep(bitStep), .subMode(subMode),
    .pairA(pairA), .pairB(pairB), .sumOut(sumOut), .errFlag(errFlag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyStep(input logic [1:0] pa, input logic [1:0] pb,
                           input logic sub, input logic step, output logic [1:0] res);
    @(negedge clk);
    pairA = pa; pairB = pb; subMode = sub; bitStep = step;
    @(posedge clk);
    #1 res = sumOut;
  endtask

  function automatic logic [1:0] enc(input logic v);
    return {v, ~v};
  endfunction

  task automatic runOp(input logic isSub, input logic [NB-1:0] a, input logic [NB-1:0] b);
    logic [1:0] r;
    logic [NB-1:0] got, exp;
    bit encOk;
    encOk = 1'b1;
    // preamble: add clears carry (0,0); sub sets it (A=1, raw B=0 -> swapped 1)
    applyStep(enc(isSub), enc(1'b0), isSub, 1'b1, r);
    for (int i = 0; i < NB; i++) begin
      applyStep(enc(a[i]), enc(b[i]), isSub, 1'b1, r);
      got[i] = r[1];
      if (r[1] == r[0]) encOk = 1'b0;
    end
    exp = isSub ? (a - b) : (a + b);
    check(encOk, "R1 sum pair encoding", 0, 0);
    check(got == exp, isSub ? "R4 subtract" : "R2/R3 add", int'(got), int'(exp));
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [1:0] r;
    repeat (3) @(posedge clk);
    #1;
    check(sumOut == 2'b00, "R8 reset sumOut", sumOut, 0);
    check(errFlag == 1'b0, "R8 reset errFlag", errFlag, 0);
    @(negedge clk); rst = 1'b0;

    for (int v = 0; v < NVEC; v++)
      runOp(VEC[v][2*NB], VEC[v][2*NB-1:NB], VEC[v][NB-1:0]);

    for (int k = 0; k < 24; k++)
      runOp(1'($urandom), NB'($urandom), NB'($urandom));
    check(errFlag == 1'b0, "R5 no flag on clean traffic", errFlag, 0);

    // R3: set then observe carry through a 0,0 step
    applyStep(2'b10, 2'b10, 1'b0, 1'b1, r);
    applyStep(2'b01, 2'b01, 1'b0, 1'b1, r);
    check(r == 2'b10, "R3 carry set by 1,1", r, 2'b10);
    applyStep(2'b01, 2'b01, 1'b0, 1'b1, r);
    check(r == 2'b01, "R3 carry cleared by 0,0", r, 2'b01);

    // R7: idle with broken pairs, carry set beforehand
    applyStep(2'b10, 2'b10, 1'b0, 1'b1, r);
    applyStep(2'b11, 2'b00, 1'b0, 1'b0, r);
    check(r == 2'b00, "R7 idle sumOut", r, 0);
    check(errFlag == 1'b0, "R7 idle no flag", errFlag, 0);
    applyStep(2'b01, 2'b01, 1'b0, 1'b1, r);
    check(r == 2'b10, "R7 carry held over idle", r, 2'b10);

    // R5/R6: drop a rail on A while carry is set
    applyStep(2'b10, 2'b10, 1'b0, 1'b1, r);
    applyStep(2'b00, 2'b01, 1'b0, 1'b1, r);
    check(r == 2'b00, "R6 fault step sumOut", r, 0);
    check(errFlag == 1'b1, "R5 flag on dropped rail", errFlag, 1);
    applyStep(2'b01, 2'b01, 1'b0, 1'b1, r);
    check(r == 2'b10, "R6 carry held over fault", r, 2'b10);
    check(errFlag == 1'b1, "R5 flag sticky", errFlag, 1);

    // R8: reset clears flag and carry
    @(negedge clk); rst = 1'b1; bitStep = 1'b0;
    @(negedge clk); rst = 1'b0;
    #1;
    check(errFlag == 1'b0, "R8 reset clears flag", errFlag, 0);
    applyStep(2'b01, 2'b01, 1'b0, 1'b1, r);
    check(r == 2'b01, "R8 reset clears carry", r, 2'b01);

    // R5: double token on B with subtract swap
    applyStep(2'b10, 2'b11, 1'b1, 1'b1, r);
    check(r == 2'b00 && errFlag == 1'b1, "R5 double token on B", {errFlag, r}, 3'b100);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule